// File: doc/BRIEF.md
# Serial Flash Slave Hold Controller

This block sits between the pins of a serial flash slave and its internal bit shifter. It watches chip select, the serial clock and an active-low pause pin, and turns them into qualified strobes for the shifter. One strobe marks each rising serial clock edge, where input bits are taken. The other marks each falling edge, where output bits advance. It also drives the output-enable of the data-out pin and passes the shifter's serial data through to that pin.

While the pause pin is low, the block freezes the transfer without losing its place. Both strobes stay quiet and the data-out pin floats. The pause state is only entered or left while the serial clock is low. A request made while the clock is high waits for the next low phase. If chip select rises during a pause, the block gives the internal logic a one-cycle reset pulse and drops the pause.

Every pin is retimed by a configurable synchroniser into a system clock that runs much faster than the serial clock. Clock polarity modes 0 and 3 both work, because only edges are used. A status output shows whether the pause is in force.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, samp_en, shift_en, so_oe, int_rst and hold_active are all 0.
- R2: With chip select low and no pause, each rising serial clock edge gives exactly one one-cycle samp_en pulse. The pulse appears SYNC_STAGES+1 system clocks after the pin change.
- R3: With chip select low and no pause, each falling serial clock edge gives exactly one one-cycle shift_en pulse, with the same latency as R2.
- R4: When hold_n_pin goes low while the serial clock is low and chip select is low, hold_active becomes 1 with the same latency as R2.
- R5: If hold_n_pin goes low while the serial clock is high, hold_active stays 0 until the serial clock next goes low. The pause state only ever changes while the synchronised serial clock is low or chip select is high.
- R6: The pause ends when hold_n_pin is high while the serial clock is low. If hold_n_pin rises while the serial clock is high, hold_active stays 1 until the serial clock next goes low.
- R7: While hold_active is 1, samp_en, shift_en and so_oe are all 0, whatever the serial clock and data do.
- R8: While chip select is high, hold_active is 0 and hold_n_pin has no effect.
- R9: A rise of chip select during a pause gives a single one-cycle int_rst pulse and clears hold_active.
- R10: so_oe is 1 exactly while chip select is low and no pause is in force (same latency as R2). sdo_out repeats sdo_in one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| sdo_in | input | 1 | Serial data from the internal shifter |
| samp_en | output | 1 | One-cycle strobe per qualified rising serial clock edge |
| shift_en | output | 1 | One-cycle strobe per qualified falling serial clock edge |
| so_oe | output | 1 | Output-enable for the data-out pin |
| sdo_out | output | 1 | Registered serial data toward the data-out pin |
| int_rst | output | 1 | One-cycle reset pulse for the internal logic |
| hold_active | output | 1 | Pause state in force |

## Verification
The most delicate coincidence is a pause request arriving in the same system cycle as a serial clock edge. A falling edge that also enters the pause must be suppressed. A falling edge that ends the pause must pass. The bench provokes this by toggling hold_n_pin while the serial clock is high, then lowering the clock. The same pin pattern drives a behavioural model, whose enables and pause state are compared with the design on every clock. A second coincidence is chip select rising while a pause is held. Here the reset pulse and the clearing of the pause must land in the same cycle, and the bench counts exactly one int_rst pulse.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    localparam int unsigned PIN_W = 3;

    // synchronised pin bundle, bit order {cs_n, sck, hold_n}
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic hold_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1};

    typedef struct packed {
        logic hold;
        logic cs_prev;
        logic sck_prev;
        logic rst;
    } pause_st_t;

    typedef struct packed {
        logic samp;
        logic shift;
        logic oe;
        logic dout;
    } gate_st_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] stage_d;
            if (g == 0) begin : g_first
                always_comb stage_d = din;
            end else begin : g_next
                always_comb stage_d = stage_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d;
            end
        end
    endgenerate

    assign dout = stage_q[LAST];
endmodule

// File: rtl/spi_hold_pause.sv
module spi_hold_pause
    import spi_hold_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_s,
    output logic  hold_nxt,
    output logic  hold_cur,
    output logic  sck_rise,
    output logic  sck_fall,
    output logic  rst_pulse
);
    pause_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.cs_prev  = pins_s.cs_n;
        st_d.sck_prev = pins_s.sck;
        if (pins_s.cs_n)
            st_d.hold = 1'b0;
        else if (!pins_s.sck)
            st_d.hold = ~pins_s.hold_n;
        st_d.rst = pins_s.cs_n & ~st_q.cs_prev & st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hold: 1'b0, cs_prev: 1'b1, sck_prev: 1'b0, rst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_nxt  = st_d.hold;
    assign hold_cur  = st_q.hold;
    assign sck_rise  = pins_s.sck & ~st_q.sck_prev;
    assign sck_fall  = ~pins_s.sck & st_q.sck_prev;
    assign rst_pulse = st_q.rst;

    // pause state moves only during a low serial clock or a deselect
    assert_hold_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.hold) |-> $past(!pins_s.sck || pins_s.cs_n));

    assert_no_hold_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s.cs_n |=> !st_q.hold);

    assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |=> !st_q.rst);

    assert_rst_clears_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> !st_q.hold);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic hold_nxt,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic sdo_in,
    output logic samp_en,
    output logic shift_en,
    output logic so_oe,
    output logic sdo_out
);
    gate_st_t st_d, st_q;
    logic     live;

    always_comb begin
        live       = ~cs_n_s & ~hold_nxt;
        st_d       = st_q;
        st_d.samp  = sck_rise & live;
        st_d.shift = sck_fall & live;
        st_d.oe    = live;
        st_d.dout  = sdo_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign samp_en  = st_q.samp;
    assign shift_en = st_q.shift;
    assign so_oe    = st_q.oe;
    assign sdo_out  = st_q.dout;

    assert_edges_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.samp |-> !st_q.shift);

    assert_samp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.samp |=> !st_q.samp);

    assert_shift_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.shift |=> !st_q.shift);
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic hold_n_pin,
    input  logic sdo_in,
    output logic samp_en,
    output logic shift_en,
    output logic so_oe,
    output logic sdo_out,
    output logic int_rst,
    output logic hold_active
);
    pins_t pins_raw, pins_s;
    logic  hold_nxt, sck_rise, sck_fall;

    assign pins_raw = '{cs_n: cs_n_pin, sck: sck_pin, hold_n: hold_n_pin};

    spi_hold_sync #(
        .STAGES (SYNC_STAGES),
        .W      (PIN_W),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    spi_hold_pause u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_s   (pins_s),
        .hold_nxt (hold_nxt),
        .hold_cur (hold_active),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .rst_pulse(int_rst)
    );

    spi_hold_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s.cs_n),
        .hold_nxt(hold_nxt),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .sdo_in  (sdo_in),
        .samp_en (samp_en),
        .shift_en(shift_en),
        .so_oe   (so_oe),
        .sdo_out (sdo_out)
    );

    assert_quiet_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!samp_en && !shift_en && !so_oe));

    assert_rst_from_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst |-> $past(hold_active));
endmodule

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, sdo = 1'b0;
    logic samp_en, shift_en, so_oe, sdo_out, int_rst, hold_active;

    int checks = 0;
    int errors = 0;
    int samp_cnt = 0;
    int rst_cnt = 0;

    always #2.5 clk = ~clk;

    spi_hold_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck),
        .hold_n_pin(hold_n), .sdo_in(sdo), .samp_en(samp_en),
        .shift_en(shift_en), .so_oe(so_oe), .sdo_out(sdo_out),
        .int_rst(int_rst), .hold_active(hold_active)
    );

    // reference model: pin history of {cs_n, sck, hold_n, sdo}, newest first
    logic [3:0] hist[$];
    logic m_hold = 1'b0;
    logic e_samp = 1'b0, e_shift = 1'b0, e_oe = 1'b0, e_dout = 1'b0, e_rst = 1'b0;

    initial begin
        for (int i = 0; i < 4; i++) hist.push_back(4'b1010);
    end

    always @(posedge clk) begin
        if (rst_n) begin
            logic c, s, h, cp, sp, nh;
            hist.push_front({cs_n, sck, hold_n, sdo});
            void'(hist.pop_back());
            c  = hist[2][3]; s  = hist[2][2]; h = hist[2][1];
            cp = hist[3][3]; sp = hist[3][2];
            nh = c ? 1'b0 : (s ? m_hold : ~h);
            e_samp  = s & ~sp & ~c & ~nh;
            e_shift = ~s & sp & ~c & ~nh;
            e_oe    = ~c & ~nh;
            e_dout  = hist[0][0];
            e_rst   = c & ~cp & m_hold;
            m_hold  = nh;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 samp_en", samp_en, e_samp);
            chk("R3 shift_en", shift_en, e_shift);
            chk("R4 hold_active", hold_active, m_hold);
            chk("R10 so_oe", so_oe, e_oe);
            chk("R10 sdo_out", sdo_out, e_dout);
            chk("R9 int_rst", int_rst, e_rst);
            if (samp_en === 1'b1) samp_cnt++;
            if (int_rst === 1'b1) rst_cnt++;
            sdo = ~sdo ^ sck;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_m0(input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; wt(8); sck = 1'b0; wt(8);
        end
    endtask

    task automatic pulse_m3(input int n);
        for (int i = 0; i < n; i++) begin
            sck = 1'b0; wt(8); sck = 1'b1; wt(8);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        wt(4);
        chk("R1 samp_en reset", samp_en, 1'b0);
        chk("R1 so_oe reset", so_oe, 1'b0);
        chk("R1 hold_active reset", hold_active, 1'b0);
        chk("R1 int_rst reset", int_rst, 1'b0);
        rst_n = 1'b1;
        wt(6);
        // mode 0 transfer
        cs_n = 1'b0; wt(6);
        base = samp_cnt; pulse_m0(4);
        chk("R2 four rising edges", samp_cnt == base + 4, 1'b1);
        // pause entered with clock low
        hold_n = 1'b0; wt(4);
        chk("R4 hold entry", hold_active, 1'b1);
        base = samp_cnt; pulse_m0(3);
        chk("R7 no strobes in pause", samp_cnt == base, 1'b1);
        chk("R7 so_oe off in pause", so_oe, 1'b0);
        hold_n = 1'b1; wt(4);
        chk("R6 exit with clock low", hold_active, 1'b0);
        // deferred entry and exit
        sck = 1'b1; wt(4); hold_n = 1'b0; wt(10);
        chk("R5 entry deferred", hold_active, 1'b0);
        sck = 1'b0; wt(4);
        chk("R5 entry on low clock", hold_active, 1'b1);
        sck = 1'b1; wt(4); hold_n = 1'b1; wt(10);
        chk("R6 exit deferred", hold_active, 1'b1);
        sck = 1'b0; wt(4);
        chk("R6 exit on low clock", hold_active, 1'b0);
        pulse_m0(2);
        // deselect during pause
        hold_n = 1'b0; wt(6);
        base = rst_cnt; cs_n = 1'b1; wt(6);
        chk("R9 one reset pulse", rst_cnt == base + 1, 1'b1);
        chk("R9 pause cleared", hold_active, 1'b0);
        // pause pin while deselected
        pulse_m0(2);
        chk("R8 no pause deselected", hold_active, 1'b0);
        hold_n = 1'b1; wt(6);
        // mode 3 transfer
        sck = 1'b1; wt(6); cs_n = 1'b0; wt(6);
        base = samp_cnt; pulse_m3(5);
        chk("R2 mode 3 rising edges", samp_cnt == base + 5, 1'b1);
        hold_n = 1'b0; wt(4);
        chk("R5 mode 3 idle high defers", hold_active, 1'b0);
        sck = 1'b0; wt(4);
        chk("R4 mode 3 entry", hold_active, 1'b1);
        hold_n = 1'b1; wt(4); sck = 1'b1; wt(6);
        cs_n = 1'b1; wt(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule